// File: doc/BRIEF.md
# Oversampled Serial Receiver with Majority Vote

This block receives asynchronous serial characters (one start bit, `DATA_W` data bits sent least significant bit first, one stop bit) from a single input line. A tick enable at `OSR` times the baud rate drives it. For each bit position the line is sampled three times around the middle of the bit. A 2-of-3 majority vote sets the bit value. If the three samples disagree, the character is marked as noisy.

A finished character moves in one step from the shift register into a holding data register. The next character can then shift in while the previous one waits to be read. The block reports data-ready, overrun, noise, framing-error and idle-line status. A read strobe consumes the held character. An inhibit input from sleep control holds every flag clear.

Top module: `srx_rx`

## Requirements
- R1: Each bit value is the 2-of-3 majority of the line samples taken at oversample ticks OSR/2-1, OSR/2 and OSR/2+1, counted from the tick on which the falling start edge is seen as tick 0. Data bits arrive least significant bit first.
- R2: If the three samples of any bit in a character (start, data or stop) are not all equal, `noise_o` is set when that character is transferred. A single flipped sample does not change the bit value.
- R3: If the start-bit vote is high, the edge is a false start. The receiver returns to hunting for an edge and transfers no character.
- R4: A completed character is copied to `data_o` and sets `full_o`. `data_o` keeps its value until the next transfer.
- R5: If a character completes while `full_o` is set and no read is strobed, `overrun_o` is set. The new character is discarded and `data_o` keeps the held character.
- R6: If the stop-bit vote is low, `frame_err_o` is set. The character is still transferred.
- R7: After a character, `idle_o` sets once the line has been high for (DATA_W+2)*OSR consecutive ticks. Any low sample restarts the count. `idle_o` clears when a new start bit is accepted or on a read.
- R8: A one-cycle `rd_i` pulse clears `full_o`, `overrun_o`, `noise_o`, `frame_err_o` and `idle_o`.
- R9: While `inhibit_i` is high, all five flags are held at 0 and no character is transferred to `data_o`.
- R10: After reset all flags are 0 and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversample enable, OSR per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| rd_i | input | 1 | Read strobe for the data register |
| inhibit_i | input | 1 | Sleep inhibit: holds all flags clear |
| data_o | output | DATA_W | Holding data register |
| full_o | output | 1 | Data register holds an unread character |
| overrun_o | output | 1 | Character lost while register was full |
| noise_o | output | 1 | Sample disagreement in held character |
| frame_err_o | output | 1 | Stop bit of held character voted low |
| idle_o | output | 1 | Line idle for one frame after a character |

## Verification
The bench builds the block with its defaults: OSR=16, DATA_W=8 and two synchronizer stages, with `tick_i` pulsing every second clock. These values make the 160-tick idle window short enough to run both just below and well beyond it. Because each line sample lasts exactly one tick, the bench can flip a single chosen sample (the middle vote position) in the start bit, a data bit or the stop bit. That checks noise reporting without changing the voted value.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic differ3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q[g] <= RESET_VAL;
      else if (g == 0) s_q[g] <= d_i;
      else s_q[g] <= s_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              noise_o,
  output logic              ferr_o,
  output logic              start_o,
  output logic              idle_o
);
  localparam int SUB_W       = $clog2(OSR);
  localparam int BIT_W       = $clog2(DATA_W + 1);
  localparam int MID         = OSR / 2;
  localparam int FRAME_TICKS = (DATA_W + 2) * OSR;
  localparam int IDLE_W      = $clog2(FRAME_TICKS + 1);

  localparam logic [SUB_W-1:0] S0   = SUB_W'(MID - 1);
  localparam logic [SUB_W-1:0] S1   = SUB_W'(MID);
  localparam logic [SUB_W-1:0] S2   = SUB_W'(MID + 1);
  localparam logic [SUB_W-1:0] SMAX = SUB_W'(OSR - 1);

  rx_state_e          state_q;
  logic [SUB_W-1:0]   sub_q;
  logic [BIT_W-1:0]   bit_q;
  logic [1:0]         samp_q;
  logic [DATA_W-1:0]  shift_q;
  logic               nacc_q, prev_q, armed_q;
  logic [IDLE_W-1:0]  idle_cnt_q;
  logic               vote, differ;

  always_comb begin
    vote   = maj3(samp_q[0], samp_q[1], line_i);
    differ = differ3(samp_q[0], samp_q[1], line_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      sub_q      <= '0;
      bit_q      <= '0;
      samp_q     <= '0;
      shift_q    <= '0;
      nacc_q     <= 1'b0;
      prev_q     <= 1'b1;
      armed_q    <= 1'b0;
      idle_cnt_q <= '0;
      done_o     <= 1'b0;
      noise_o    <= 1'b0;
      ferr_o     <= 1'b0;
      start_o    <= 1'b0;
      idle_o     <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      start_o <= 1'b0;
      idle_o  <= 1'b0;
      if (tick_i) begin
        if (state_q == ST_HUNT) begin
          prev_q <= line_i;
          if (prev_q && !line_i) begin
            state_q <= ST_START;
            sub_q   <= SUB_W'(1);
            nacc_q  <= 1'b0;
          end
          if (armed_q) begin
            if (!line_i) idle_cnt_q <= '0;
            else if (idle_cnt_q == IDLE_W'(FRAME_TICKS - 1)) begin
              idle_o  <= 1'b1;
              armed_q <= 1'b0;
            end else idle_cnt_q <= idle_cnt_q + 1'b1;
          end
        end else begin
          sub_q <= (sub_q == SMAX) ? '0 : sub_q + 1'b1;
          if (sub_q == S0) samp_q[0] <= line_i;
          if (sub_q == S1) samp_q[1] <= line_i;
          if (sub_q == S2) begin
            unique case (state_q)
              ST_START: begin
                if (vote) begin
                  state_q <= ST_HUNT;
                  prev_q  <= line_i;
                end else begin
                  state_q <= ST_DATA;
                  bit_q   <= '0;
                  nacc_q  <= differ;
                  start_o <= 1'b1;
                end
              end
              ST_DATA: begin
                shift_q <= {vote, shift_q[DATA_W-1:1]};
                nacc_q  <= nacc_q | differ;
                bit_q   <= bit_q + 1'b1;
                if (bit_q == BIT_W'(DATA_W - 1)) state_q <= ST_STOP;
              end
              default: begin
                done_o     <= 1'b1;
                noise_o    <= nacc_q | differ;
                ferr_o     <= !vote;
                state_q    <= ST_HUNT;
                prev_q     <= line_i;
                armed_q    <= 1'b1;
                idle_cnt_q <= '0;
              end
            endcase
          end
        end
      end
    end
  end

  assign word_o = shift_q;

  // R1
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BIT_W'(DATA_W));

  // R6
  done_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q) == ST_STOP);

  // R3
  false_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_START && sub_q == S2 && samp_q == 2'b11) |=> state_q == ST_HUNT);
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              noise_i,
  input  logic              ferr_i,
  input  logic              start_i,
  input  logic              idle_i,
  input  logic              rd_i,
  input  logic              inhibit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              noise_o,
  output logic              ferr_o,
  output logic              idle_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      full_o  <= 1'b0;
      ovr_o   <= 1'b0;
      noise_o <= 1'b0;
      ferr_o  <= 1'b0;
      idle_o  <= 1'b0;
    end else if (inhibit_i) begin
      full_o  <= 1'b0;
      ovr_o   <= 1'b0;
      noise_o <= 1'b0;
      ferr_o  <= 1'b0;
      idle_o  <= 1'b0;
    end else begin
      if (rd_i) begin
        full_o  <= 1'b0;
        ovr_o   <= 1'b0;
        noise_o <= 1'b0;
        ferr_o  <= 1'b0;
        idle_o  <= 1'b0;
      end
      if (start_i) idle_o <= 1'b0;
      if (idle_i)  idle_o <= 1'b1;
      if (done_i) begin
        if (full_o && !rd_i) ovr_o <= 1'b1;
        else begin
          data_o  <= word_i;
          full_o  <= 1'b1;
          noise_o <= noise_i;
          ferr_o  <= ferr_i;
        end
      end
    end
  end

  // R9
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !(full_o | ovr_o | noise_o | ferr_o | idle_o));

  // R5
  overrun_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_o && !rd_i && !inhibit_i) |=> ovr_o && $stable(data_o));

  // R4
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !full_o && !inhibit_i) |=> full_o && data_o == $past(word_i));

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i && !inhibit_i) |=> !(full_o | ovr_o | noise_o | ferr_o));
endmodule

// File: rtl/srx_rx.sv
module srx_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  input  logic              inhibit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              noise_o,
  output logic              frame_err_o,
  output logic              idle_o
);
  logic              line_s;
  logic              done, f_noise, f_ferr, f_start, f_idle;
  logic [DATA_W-1:0] word;

  srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  srx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .line_i (line_s),
    .done_o (done),
    .word_o (word),
    .noise_o(f_noise),
    .ferr_o (f_ferr),
    .start_o(f_start),
    .idle_o (f_idle)
  );

  srx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .word_i   (word),
    .noise_i  (f_noise),
    .ferr_i   (f_ferr),
    .start_i  (f_start),
    .idle_i   (f_idle),
    .rd_i     (rd_i),
    .inhibit_i(inhibit_i),
    .data_o   (data_o),
    .full_o   (full_o),
    .ovr_o    (overrun_o),
    .noise_o  (noise_o),
    .ferr_o   (frame_err_o),
    .idle_o   (idle_o)
  );

  // R7
  idle_needs_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> !$past(inhibit_i));
endmodule

// File: tb/srx_rx_tb.sv
module srx_rx_tb_top;
  localparam int OSR    = 16;
  localparam int DATA_W = 8;
  localparam int NVEC   = 7;
  // {data[15:8], noisy bit[7:4] (0 start, 1..8 data, 9 stop, F none), stop_low, exp_noise, exp_ferr, 0}
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA5F0, 16'h00F0, 16'hFFF0, 16'h3C34, 16'h81FA, 16'h5A94, 16'h7E04
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i, rxd_i = 1'b1, rd_i = 1'b0, inhibit_i = 1'b0;
  logic [DATA_W-1:0] data_o;
  logic full_o, overrun_o, noise_o, frame_err_o, idle_o;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tick_i <= 1'b0;
    else tick_i <= ~tick_i;

  srx_rx #(.OSR(OSR), .DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i), .rd_i(rd_i),
    .inhibit_i(inhibit_i), .data_o(data_o), .full_o(full_o), .overrun_o(overrun_o),
    .noise_o(noise_o), .frame_err_o(frame_err_o), .idle_o(idle_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    rxd_i = v;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic idle_line(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic send(input logic [7:0] d, input logic [3:0] nbit, input logic stop_low);
    for (int b = 0; b < 10; b++) begin
      for (int k = 0; k < OSR; k++) begin
        logic v;
        v = (b == 0) ? 1'b0 : (b == 9) ? !stop_low : d[b-1];
        if (b == int'(nbit) && k == OSR/2) v = ~v;
        slot(v);
      end
    end
  endtask

  task automatic read_reg();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_i);
    check("R10 full", full_o, 0);
    check("R10 flags", {overrun_o, noise_o, frame_err_o, idle_o}, 0);
    check("R10 data", data_o, 0);
    rst_ni = 1'b1;
    idle_line(20);

    // R3: short low pulse, mid-bit samples high
    for (int i = 0; i < 4; i++) slot(1'b0);
    idle_line(40);
    check("R3 false start no word", full_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][15:8], VEC[i][7:4], VEC[i][3]);
      idle_line(20);
      check("R1 data", data_o, VEC[i][15:8]);
      check("R4 full", full_o, 1);
      check("R2 noise", noise_o, VEC[i][2]);
      check("R6 frame err", frame_err_o, VEC[i][1]);
      check("R5 no overrun", overrun_o, 0);
      read_reg();
      check("R8 read clears", {full_o, overrun_o, noise_o, frame_err_o}, 0);
    end

    // R5 overrun
    send(8'hA1, 4'hF, 1'b0);
    idle_line(20);
    send(8'hB2, 4'hF, 1'b0);
    idle_line(20);
    check("R5 overrun set", overrun_o, 1);
    check("R5 held word kept", data_o, 8'hA1);
    check("R5 full", full_o, 1);
    read_reg();
    check("R8 overrun cleared", {full_o, overrun_o}, 0);

    // R7 idle
    send(8'h55, 4'hF, 1'b0);
    idle_line(100);
    check("R7 idle not yet", idle_o, 0);
    idle_line(80);
    check("R7 idle set", idle_o, 1);
    read_reg();
    send(8'h66, 4'hF, 1'b0);
    idle_line(20);
    check("R7 idle clear after start", idle_o, 0);
    check("R4 data 66", data_o, 8'h66);
    read_reg();

    // R9 inhibit
    send(8'hC3, 4'hF, 1'b0);
    idle_line(20);
    check("R9 pre full", full_o, 1);
    inhibit_i = 1'b1;
    idle_line(2);
    check("R9 flags held clear", {full_o, overrun_o, noise_o, frame_err_o, idle_o}, 0);
    send(8'hD4, 4'h4, 1'b1);
    idle_line(20);
    check("R9 no transfer", data_o, 8'hC3);
    check("R9 flags stay clear", {full_o, overrun_o, noise_o, frame_err_o, idle_o}, 0);
    inhibit_i = 1'b0;
    idle_line(2);
    check("R9 after release", {full_o, data_o}, {1'b0, 8'hC3});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule